// File: doc/BRIEF.md
# Multi-Resolution Panel Sync Timing Generator

This block produces the raster timing for a parallel 24-bit RGB flat panel: a horizontal sync, a vertical sync and a data-enable that is high only over the visible pixels. It also gives a pixel source the zero-based column and row of the current active pixel, plus one-clock strobes that mark the start of every line and the start of every frame. It runs entirely in the pixel-clock domain. Pixel data, frame buffer access and pixel clock generation are handled elsewhere.

A two-bit resolution select picks one of three built-in timing sets at run time. A new selection is taken up only at the next frame boundary, so a frame in progress is never cut short. Two separate inputs set the active level of each sync output. The sync pulse opens every line and every frame. The back porch is counted from the first clock of that pulse.

Top module: `lcd_tmg_gen`

## Requirements
- R1: With the resolution select at 0, a line lasts 1056 clocks and DEN first rises 35 lines plus 216 clocks after the frame starts.
- R2: With the resolution select at 1, a line lasts 525 clocks and DEN first rises 12 lines plus 43 clocks after the frame starts.
- R3: With the resolution select at 2, a line lasts 528 clocks and a frame lasts 262 lines (138336 clocks). Select value 3 behaves as value 0.
- R4: HD is active for HSYNC_W clocks starting at column count 0 of every line. VD is active for VSYNC_W whole lines starting at line 0 of every frame.
- R5: DEN is high for exactly the active-width clocks of each active line and low in every porch and sync interval. For select 2 this gives 96000 DEN-high clocks per frame.
- R6: A polarity input of 0 makes its sync output an active-low pulse and 1 makes it an active-high pulse. The inactive level is the inverse.
- R7: col_o and row_o count from 0 inside the active area, with col_o rising by 1 per clock along a line. Both are 0 whenever DEN is low. The last active row is the active height minus 1.
- R8: sol_o pulses for one clock at the first clock of every line. sof_o pulses at the first clock of every frame and coincides with an sol_o pulse.
- R9: A change of the resolution select during a frame does not alter that frame. The next frame starts with both counters at zero and uses the new timing.
- R10: While rst_ni is low, DEN, col_o, row_o and both strobes are 0 and both syncs sit at their inactive level. The first sof_o appears on the second clock edge after reset release.

Ports:
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Resolution select: 0 = 800x480, 1 = 480x272, 2 = 400x240, 3 = as 0 |
| hd_pol_i | input | 1 | HD active level (0 low, 1 high) |
| vd_pol_i | input | 1 | VD active level (0 low, 1 high) |
| hd_o | output | 1 | Horizontal sync |
| vd_o | output | 1 | Vertical sync |
| den_o | output | 1 | Data enable, high in the active area |
| col_o | output | COL_W | Active column, 0 outside the active area |
| row_o | output | ROW_W | Active row, 0 outside the active area |
| sol_o | output | 1 | Start-of-line strobe |
| sof_o | output | 1 | Start-of-frame strobe |

## Verification
The assertions check the local relations on every clock. The coordinates are zero while DEN is low, the column advances by one along each active run and restarts at zero when DEN rises, no sync overlaps DEN, and every strobe lines up with its sync edge and with the other strobe. Quantities that span thousands of clocks can only be shown by the bench scenarios: the line and frame lengths of each preset, the back-porch offset to the first active pixel, and the run length of DEN. The same applies to the rule that a resolution change waits for the frame boundary and to the reset-release latency.

// File: rtl/lcd_tmg_pkg.sv
package lcd_tmg_pkg;

  localparam int TW = 11;

  typedef enum logic [1:0] {
    RES_800X480 = 2'd0,
    RES_480X272 = 2'd1,
    RES_400X240 = 2'd2,
    RES_RSVD    = 2'd3
  } res_e;

  typedef struct packed {
    logic [TW-1:0] h_tot;
    logic [TW-1:0] h_bp;
    logic [TW-1:0] h_act;
    logic [TW-1:0] v_tot;
    logic [TW-1:0] v_bp;
    logic [TW-1:0] v_act;
  } tmg_t;

  function automatic tmg_t preset_of(res_e res);
    tmg_t t;
    case (res)
      RES_480X272: begin
        t.h_tot = TW'(525);  t.h_bp = TW'(43);  t.h_act = TW'(480);
        t.v_tot = TW'(286);  t.v_bp = TW'(12);  t.v_act = TW'(272);
      end
      RES_400X240: begin
        t.h_tot = TW'(528);  t.h_bp = TW'(108); t.h_act = TW'(400);
        t.v_tot = TW'(262);  t.v_bp = TW'(20);  t.v_act = TW'(240);
      end
      default: begin
        t.h_tot = TW'(1056); t.h_bp = TW'(216); t.h_act = TW'(800);
        t.v_tot = TW'(525);  t.v_bp = TW'(35);  t.v_act = TW'(480);
      end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/lcd_tmg_preset.sv
module lcd_tmg_preset
  import lcd_tmg_pkg::*;
(
  input  res_e res_i,
  output tmg_t tmg_o
);
  always_comb tmg_o = preset_of(res_i);
endmodule

// File: rtl/lcd_tmg_axis.sv
// One raster axis: wrapping counter with sync, active window and position decode.
module lcd_tmg_axis #(
  parameter int TW     = 11,
  parameter int SYNC_W = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          step_i,
  input  logic [TW-1:0] tot_i,
  input  logic [TW-1:0] bp_i,
  input  logic [TW-1:0] act_i,
  output logic [TW-1:0] cnt_o,
  output logic          last_o,
  output logic          sync_o,
  output logic          act_o,
  output logic [TW-1:0] pos_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] end_w;

  assign end_w  = bp_i + act_i;
  assign last_o = (cnt_q == tot_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + TW'(1);
  end

  assign cnt_o  = cnt_q;
  assign sync_o = (cnt_q < TW'(SYNC_W));
  assign act_o  = (cnt_q >= bp_i) && (cnt_q < end_w);
  assign pos_o  = cnt_q - bp_i;
endmodule

// File: rtl/lcd_tmg_gen.sv
module lcd_tmg_gen
  import lcd_tmg_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int ROW_W   = 9,
  parameter int HSYNC_W = 1,
  parameter int VSYNC_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             hd_pol_i,
  input  logic             vd_pol_i,
  output logic             hd_o,
  output logic             vd_o,
  output logic             den_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             sol_o,
  output logic             sof_o
);
  logic          st_q;
  res_e          res_q;
  tmg_t          tmg;
  logic [TW-1:0] h_cnt, v_cnt, h_pos, v_pos;
  logic          h_last, v_last, h_sync, v_sync, h_act, v_act;
  logic          wrap, den_d;

  logic             hs_q, vs_q, den_q, sol_q, sof_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  // Mode is sampled once after reset and then only at the frame wrap.
  assign wrap = !st_q || (h_last && v_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= 1'b0;
      res_q <= RES_800X480;
    end else begin
      st_q <= 1'b1;
      if (wrap) res_q <= res_e'(mode_i);
    end
  end

  lcd_tmg_preset i_preset (
    .res_i (res_q),
    .tmg_o (tmg)
  );

  lcd_tmg_axis #(.TW(TW), .SYNC_W(HSYNC_W)) i_h_axis (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q),
    .step_i (1'b1),
    .tot_i  (tmg.h_tot),
    .bp_i   (tmg.h_bp),
    .act_i  (tmg.h_act),
    .cnt_o  (h_cnt),
    .last_o (h_last),
    .sync_o (h_sync),
    .act_o  (h_act),
    .pos_o  (h_pos)
  );

  lcd_tmg_axis #(.TW(TW), .SYNC_W(VSYNC_W)) i_v_axis (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q),
    .step_i (h_last),
    .tot_i  (tmg.v_tot),
    .bp_i   (tmg.v_bp),
    .act_i  (tmg.v_act),
    .cnt_o  (v_cnt),
    .last_o (v_last),
    .sync_o (v_sync),
    .act_o  (v_act),
    .pos_o  (v_pos)
  );

  assign den_d = st_q && h_act && v_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      den_q <= 1'b0;
      sol_q <= 1'b0;
      sof_q <= 1'b0;
      col_q <= '0;
      row_q <= '0;
    end else begin
      hs_q  <= st_q && h_sync;
      vs_q  <= st_q && v_sync;
      den_q <= den_d;
      sol_q <= st_q && (h_cnt == '0);
      sof_q <= st_q && (h_cnt == '0) && (v_cnt == '0);
      col_q <= den_d ? COL_W'(h_pos) : '0;
      row_q <= den_d ? ROW_W'(v_pos) : '0;
    end
  end

  // Polarity applied after the register so reset always gives the inactive level.
  assign hd_o  = ~(hs_q ^ hd_pol_i);
  assign vd_o  = ~(vs_q ^ vd_pol_i);
  assign den_o = den_q;
  assign col_o = col_q;
  assign row_o = row_q;
  assign sol_o = sol_q;
  assign sof_o = sof_q;
endmodule

// File: rtl/lcd_tmg_chk.sv
module lcd_tmg_chk #(
  parameter int COL_W = 10,
  parameter int ROW_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hd_pol_i,
  input logic             vd_pol_i,
  input logic             hd_o,
  input logic             vd_o,
  input logic             den_o,
  input logic [COL_W-1:0] col_o,
  input logic [ROW_W-1:0] row_o,
  input logic             sol_o,
  input logic             sof_o
);
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !den_o |-> (col_o == '0 && row_o == '0));

  assert_col_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_o && $past(den_o)) |-> col_o == $past(col_o) + COL_W'(1));

  assert_den_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(den_o) |-> col_o == '0);

  assert_sync_blank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hd_o == hd_pol_i) |-> !den_o);

  assert_sof_sol_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> sol_o);

  assert_sol_hd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_o |-> hd_o == hd_pol_i);

  assert_sof_vd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> vd_o == vd_pol_i);
endmodule

bind lcd_tmg_gen lcd_tmg_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) i_lcd_tmg_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hd_pol_i (hd_pol_i),
  .vd_pol_i (vd_pol_i),
  .hd_o     (hd_o),
  .vd_o     (vd_o),
  .den_o    (den_o),
  .col_o    (col_o),
  .row_o    (row_o),
  .sol_o    (sol_o),
  .sof_o    (sof_o)
);

// File: tb/test_lcd_tmg_gen.sv
`timescale 1ns/1ps
module test_lcd_tmg_gen;
  localparam int COL_W = 10;
  localparam int ROW_W = 9;
  localparam int WD_LIMIT = 195000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       mode_i = 2'd0;
  logic             hd_pol_i = 1'b0;
  logic             vd_pol_i = 1'b0;
  logic             hd_o, vd_o, den_o, sol_o, sof_o;
  logic [COL_W-1:0] col_o;
  logic [ROW_W-1:0] row_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int off, sols, dens, hds, vds, idle_bad, maxrow;

  always #5 clk_i = ~clk_i;

  lcd_tmg_gen #(.COL_W(COL_W), .ROW_W(ROW_W)) i_lcd_tmg_gen (
    .clk_i, .rst_ni, .mode_i, .hd_pol_i, .vd_pol_i,
    .hd_o, .vd_o, .den_o, .col_o, .row_o, .sol_o, .sof_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_tally();
    off = 0; sols = 0; dens = 0; hds = 0; vds = 0; idle_bad = 0; maxrow = 0;
  endtask

  task automatic step();
    @(negedge clk_i);
    off++;
    if (sol_o) sols++;
    if (den_o) dens++;
    if (hd_o == hd_pol_i) hds++;
    if (vd_o == vd_pol_i) vds++;
    if (!den_o && (col_o != '0 || row_o != '0)) idle_bad++;
    if (den_o && int'(row_o) > maxrow) maxrow = int'(row_o);
  endtask

  // Reset with given mode and polarities; checks idle outputs and first-sof latency.
  task automatic t_reset(input logic [1:0] mode, input logic hp, input logic vp);
    mode_i = mode; hd_pol_i = hp; vd_pol_i = vp;
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(hd_o == ~hp, "R10 hd idle", hd_o, ~hp);
    check(vd_o == ~vp, "R10 vd idle", vd_o, ~vp);
    check(!den_o && !sol_o && !sof_o && col_o == 0 && row_o == 0,
          "R10 outputs zero", {den_o, sol_o, sof_o}, 0);
    rst_ni = 1'b1;
    clear_tally();
    while (!sof_o && off < 10) step();
    check(off == 2, "R10 first sof latency", off, 2);
  endtask

  // Called at a sof negedge: line length, sync widths, back porch, active run.
  task automatic t_mode(input string req, input int ht, input int hbp, input int hact, input int vbp);
    int run, lastcol;
    check(hd_o == hd_pol_i && vd_o == vd_pol_i && sol_o, "R4 R6 sync at frame start",
          {hd_o, vd_o}, {hd_pol_i, vd_pol_i});
    clear_tally();
    while (off < ht - 1) step();
    check(hds == 0, "R4 hd width", hds + 1, 1);
    check(vds == ht - 1, "R4 vd one line", vds + 1, ht);
    step();
    check(sol_o && sols == 1, {req, " line length"}, off, ht);
    while (!den_o && off < 60000) step();
    check(off == vbp * ht + hbp, {req, " R5 first active pixel"}, off, vbp * ht + hbp);
    check(col_o == 0 && row_o == 0, "R7 first coordinate", {col_o, row_o}, 0);
    run = 0; lastcol = 0;
    while (den_o && run < 2000) begin
      run++; lastcol = int'(col_o); step();
    end
    check(run == hact, "R5 active run", run, hact);
    check(lastcol == hact - 1, "R7 last column", lastcol, hact - 1);
  endtask

  task automatic t_mode0();
    t_reset(2'd0, 1'b0, 1'b0);
    t_mode("R1", 1056, 216, 800, 35);
  endtask

  task automatic t_mode1_pol();
    t_reset(2'd1, 1'b1, 1'b1);
    t_mode("R2 R6", 525, 43, 480, 12);
  endtask

  // Full 400x240 frame, select changed mid-frame to 480x272.
  task automatic t_frame_switch();
    t_reset(2'd2, 1'b0, 1'b0);
    clear_tally();
    t_mode("R3", 528, 108, 400, 20);
    mode_i = 2'd1;
    while (!sof_o && off < 140000) step();
    check(off == 138336, "R3 R9 frame length unchanged", off, 138336);
    check(sols == 262, "R3 lines per frame", sols, 262);
    check(dens == 96000, "R5 active clocks per frame", dens, 96000);
    check(maxrow == 239, "R7 last row", maxrow, 239);
    check(idle_bad == 0, "R7 zero when idle", idle_bad, 0);
    clear_tally();
    step();
    while (!sol_o && off < 2000) step();
    check(off == 525, "R9 new line length", off, 525);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc >= WD_LIMIT) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_LIMIT);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    t_mode0();
    t_mode1_pol();
    t_frame_switch();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule